// File: doc/BRIEF.md
# PS/2 Host-to-Device Frame Receiver

This block is the device-side receive path of a PS/2 port for transfers that the host starts. Two flip-flop stages clean up the raw clock and data pins. The cleaned levels are available as status outputs. The receiver waits in idle until it sees a falling clock edge with data low, which is the start bit. On each later falling edge it samples one bit: eight data bits with the least significant bit first, then the parity bit, then the stop bit. A clean frame delivers the byte and its raw parity bit to a holding register and raises a valid flag. Software clears that flag by reading.

A stop bit of 0 sets a sticky frame-error flag and discards the byte. The receiver then stays busy and ignores any further clock edges, which an override may supply, until the data line returns high. A byte that completes while the previous byte is still unread replaces it and sets a sticky overwrite flag. Each sticky flag has its own write-1-to-clear strobe. If no falling clock edge arrives within a parameter-set number of system cycles, a watchdog returns the receiver to idle.

Top module: `ps2_hd_receiver`

## Requirements
- R1: `clk_level` and `data_level` show the pin levels after two system clock cycles of synchronization. A pin change driven between edges is not visible after the first rising edge and is visible after the second.
- R2: In idle, a falling edge of the synchronized clock with data at 0 starts a frame. The next eight falling edges sample data bits 0 to 7 with the least significant bit first, the ninth samples parity and the tenth samples the stop bit. A stop bit of 1 loads the byte into `rx_byte` and sets `rx_valid`.
- R3: `rx_parity` holds the parity bit exactly as received with the last delivered byte. It is not checked, so a byte with wrong odd parity is still delivered.
- R4: A stop bit of 0 sets `frame_err` and discards the byte. `rx_byte` and `rx_valid` keep their previous values.
- R5: After a frame error, `rx_busy` stays 1 and falling clock edges are ignored while data stays low. When data goes high the receiver returns to idle, and the next frame is received normally.
- R6: `frame_err` is sticky and is cleared by a pulse on `clr_frame_err`. If a new frame error is detected in the same cycle as the clear, the flag stays 1.
- R7: A pulse on `rd_strobe` clears `rx_valid`. If a byte completes in the same cycle as the read, `rx_valid` stays 1 and `rx_overrun` is not set.
- R8: A byte that completes while `rx_valid` is 1 and no read occurs replaces `rx_byte` and sets `rx_overrun`. That flag is sticky and is cleared by `clr_overrun`. If a new overwrite happens in the same cycle as the clear, the flag stays 1.
- R9: `rx_busy` is 1 from the start-bit edge until the frame ends, and 0 when idle.
- R10: If no falling clock edge arrives for `TIMEOUT_CYCLES` system cycles during a frame, the receiver returns to idle and discards the partial frame.
- R11: After reset the byte is 0, all flags are 0, and both level outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_pin | input | 1 | Raw PS/2 clock line |
| ps2_data_pin | input | 1 | Raw PS/2 data line |
| rd_strobe | input | 1 | Data register read pulse; clears rx_valid |
| clr_frame_err | input | 1 | Write-1-to-clear pulse for frame_err |
| clr_overrun | input | 1 | Write-1-to-clear pulse for rx_overrun |
| rx_byte | output | 8 | Last delivered byte |
| rx_parity | output | 1 | Parity bit received with rx_byte |
| rx_valid | output | 1 | Unread byte held |
| rx_busy | output | 1 | Frame in progress or draining after an error |
| frame_err | output | 1 | Sticky missing-stop-bit flag |
| rx_overrun | output | 1 | Sticky held-byte-replaced flag |
| clk_level | output | 1 | Synchronized clock pin level |
| data_level | output | 1 | Synchronized data pin level |

## Verification
Each sticky flag can be set by the frame logic in the same cycle that software clears it. A frame completion can also coincide with a read of the held byte. The bench provokes these cases by timing the strobe from the stop bit's falling clock edge. It counts the two synchronizer stages and the edge-detect register, so the strobe lands on the exact edge where the frame logic acts. The expected results are: set wins over clear, so the flag reads 1 afterwards, and a read that collides with a completion leaves `rx_valid` at 1 with no overwrite reported.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    localparam int RX_DATA_BITS = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [RX_DATA_BITS-1:0] data;
        logic                    parity;
    } rx_word_t;

    typedef struct packed {
        logic     done;
        logic     bad_stop;
        rx_word_t word;
    } rx_event_t;

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '1;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '1;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ps2rx_frame.sv
module ps2rx_frame
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 4000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clk_s,
    input  logic      data_s,
    output logic      busy,
    output rx_event_t ev
);
    localparam int CNT_W = $clog2(RX_DATA_BITS + 2);
    localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] PAR_IDX  = CNT_W'(RX_DATA_BITS);
    localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(RX_DATA_BITS + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

    rx_state_e               state;
    logic [CNT_W-1:0]        cnt;
    logic [TMR_W-1:0]        tmr;
    logic [RX_DATA_BITS-1:0] shreg;
    logic                    par;
    logic                    clk_prev;
    logic                    fall;
    logic                    at_stop;

    assign fall    = clk_prev & ~clk_s;
    assign at_stop = (state == RX_SHIFT) && fall && (cnt == STOP_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            tmr      <= '0;
            shreg    <= '0;
            par      <= 1'b0;
            clk_prev <= 1'b1;
        end else begin
            clk_prev <= clk_s;
            unique case (state)
                RX_IDLE: begin
                    tmr <= '0;
                    cnt <= '0;
                    if (fall && !data_s) state <= RX_SHIFT;
                end
                RX_SHIFT: begin
                    if (fall) begin
                        tmr <= '0;
                        if (cnt < PAR_IDX) begin
                            shreg <= {data_s, shreg[RX_DATA_BITS-1:1]};
                            cnt   <= cnt + 1'b1;
                        end else if (cnt == PAR_IDX) begin
                            par <= data_s;
                            cnt <= cnt + 1'b1;
                        end else begin
                            state <= data_s ? RX_IDLE : RX_DRAIN;
                        end
                    end else if (tmr == TMR_LAST) begin
                        state <= RX_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RX_DRAIN: begin
                    if (data_s)              state <= RX_IDLE;
                    else if (fall)           tmr   <= '0;
                    else if (tmr == TMR_LAST) state <= RX_IDLE;
                    else                     tmr   <= tmr + 1'b1;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign busy          = (state != RX_IDLE);
    assign ev.done       = at_stop & data_s;
    assign ev.bad_stop   = at_stop & ~data_s;
    assign ev.word.data  = shreg;
    assign ev.word.parity = par;
endmodule

// File: rtl/ps2rx_regs.sv
module ps2rx_regs
    import ps2rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_event_t ev,
    input  logic      rd_strobe,
    input  logic      clr_frame_err,
    input  logic      clr_overrun,
    output rx_word_t  word,
    output logic      valid,
    output logic      ferr,
    output logic      ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (ev.done) word <= ev.word;

            if (ev.done)        valid <= 1'b1;
            else if (rd_strobe) valid <= 1'b0;

            if (ev.done && valid && !rd_strobe) ovr <= 1'b1;
            else if (clr_overrun)               ovr <= 1'b0;

            if (ev.bad_stop)        ferr <= 1'b1;
            else if (clr_frame_err) ferr <= 1'b0;
        end
    end
endmodule

// File: rtl/ps2_hd_receiver.sv
module ps2_hd_receiver
    import ps2rx_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int TIMEOUT_CYCLES = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_pin,
    input  logic       ps2_data_pin,
    input  logic       rd_strobe,
    input  logic       clr_frame_err,
    input  logic       clr_overrun,
    output logic [7:0] rx_byte,
    output logic       rx_parity,
    output logic       rx_valid,
    output logic       rx_busy,
    output logic       frame_err,
    output logic       rx_overrun,
    output logic       clk_level,
    output logic       data_level
);
    logic [1:0] pins_s;
    rx_event_t  ev;
    rx_word_t   held;

    ps2rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ps2_clk_pin, ps2_data_pin}),
        .dout (pins_s)
    );

    assign clk_level  = pins_s[1];
    assign data_level = pins_s[0];

    ps2rx_frame #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .clk_s  (clk_level),
        .data_s (data_level),
        .busy   (rx_busy),
        .ev     (ev)
    );

    ps2rx_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .rd_strobe     (rd_strobe),
        .clr_frame_err (clr_frame_err),
        .clr_overrun   (clr_overrun),
        .word          (held),
        .valid         (rx_valid),
        .ferr          (frame_err),
        .ovr           (rx_overrun)
    );

    assign rx_byte   = held.data;
    assign rx_parity = held.parity;
endmodule

// File: rtl/ps2rx_checker.sv
module ps2rx_checker #(
    parameter int TIMEOUT_CYCLES = 4000
) (
    input logic       clk,
    input logic       rst,
    input logic       rd_strobe,
    input logic       clr_frame_err,
    input logic       clr_overrun,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_busy,
    input logic       frame_err,
    input logic       rx_overrun,
    input logic       clk_level
);
    logic        prev_clk;
    logic [31:0] quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b1;
            quiet    <= '0;
        end else begin
            prev_clk <= clk_level;
            quiet    <= (rx_busy && !(prev_clk && !clk_level)) ? quiet + 1 : '0;
        end
    end

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_err && !clr_frame_err |=> frame_err);                       // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_overrun && !clr_overrun |=> rx_overrun);                       // R8
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rd_strobe |=> rx_valid);                             // R7
    AST_BYTE_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> rx_valid);                                  // R2
    AST_OVR_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> rx_valid);                                  // R8
    AST_FERR_DRAINS: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> rx_busy);                                    // R5
    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        quiet <= 32'(TIMEOUT_CYCLES));                                    // R10
endmodule

bind ps2_hd_receiver ps2rx_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (.*);

// File: tb/test_ps2_hd_receiver.sv
module test_ps2_hd_receiver;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int TMO        = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps2_clk_pin = 1'b1;
    logic       ps2_data_pin = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       clr_frame_err = 1'b0;
    logic       clr_overrun = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_parity, rx_valid, rx_busy, frame_err, rx_overrun;
    logic       clk_level, data_level;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_hd_receiver #(.SYNC_STAGES(2), .TIMEOUT_CYCLES(TMO)) i_ps2_hd_receiver (
        .clk(clk), .rst(rst),
        .ps2_clk_pin(ps2_clk_pin), .ps2_data_pin(ps2_data_pin),
        .rd_strobe(rd_strobe), .clr_frame_err(clr_frame_err), .clr_overrun(clr_overrun),
        .rx_byte(rx_byte), .rx_parity(rx_parity), .rx_valid(rx_valid), .rx_busy(rx_busy),
        .frame_err(frame_err), .rx_overrun(rx_overrun),
        .clk_level(clk_level), .data_level(data_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) rd_strobe = 1'b1;
        if (which == 2) clr_frame_err = 1'b1;
        if (which == 3) clr_overrun = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0; clr_frame_err = 1'b0; clr_overrun = 1'b0;
    endtask

    // hit: 0 none, 1 read, 2 clear frame error, 3 clear overrun, timed to the stop-bit action edge
    task automatic send_frame(input logic [7:0] b, input logic p, input logic stop,
                              input int hit, input bit keep_low);
        logic [10:0] bits;
        bits = {stop, p, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            ps2_data_pin = bits[i];
            wait_cyc(HALF);
            ps2_clk_pin = 1'b0;
            if (i == 10 && hit != 0) begin
                @(posedge clk); @(posedge clk);
                pulse(hit);
                wait_cyc(HALF - 2);
            end else begin
                wait_cyc(HALF);
            end
            ps2_clk_pin = 1'b1;
        end
        wait_cyc(HALF);
        if (!keep_low) ps2_data_pin = 1'b1;
        wait_cyc(4);
    endtask

    task automatic t_reset();
        check("R11 byte", rx_byte, 0);
        check("R11 valid", rx_valid, 0);
        check("R11 busy", rx_busy, 0);
        check("R11 ferr", frame_err, 0);
        check("R11 ovr", rx_overrun, 0);
        check("R11 levels", {clk_level, data_level}, 2'b11);
    endtask

    task automatic t_levels();
        @(negedge clk); ps2_data_pin = 1'b0; ps2_clk_pin = 1'b0;
        @(negedge clk);
        check("R1 one edge", {clk_level, data_level}, 2'b11);
        @(negedge clk);
        check("R1 two edges", {clk_level, data_level}, 2'b00);
        ps2_clk_pin = 1'b1; ps2_data_pin = 1'b1;
        wait_cyc(TMO + 10);
        check("R9 idle after pin test", rx_busy, 0);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, ~^8'hA5, 1'b1, 0, 0);
        check("R2 byte", rx_byte, 8'hA5);
        check("R2 valid", rx_valid, 1);
        check("R3 parity", rx_parity, ~^8'hA5);
        check("R9 idle after frame", rx_busy, 0);
        pulse(1);
        check("R7 read clears", rx_valid, 0);
    endtask

    task automatic t_parity();
        send_frame(8'h3C, 1'b0, 1'b1, 0, 0);
        check("R3 wrong parity byte", rx_byte, 8'h3C);
        check("R3 raw parity", rx_parity, 0);
        check("R3 still valid", rx_valid, 1);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, ~^8'h11, 1'b1, 0, 0);
        check("R8 replaced", rx_byte, 8'h11);
        check("R8 flag", rx_overrun, 1);
        pulse(3);
        check("R8 clear", rx_overrun, 0);
        send_frame(8'h22, ~^8'h22, 1'b1, 3, 0);
        check("R8 set beats clear", rx_overrun, 1);
        pulse(3);
        check("R8 clear again", rx_overrun, 0);
    endtask

    task automatic t_read_clash();
        check("R7 precondition valid", rx_valid, 1);
        send_frame(8'h33, ~^8'h33, 1'b1, 1, 0);
        check("R7 valid kept", rx_valid, 1);
        check("R7 no overrun", rx_overrun, 0);
        check("R7 byte", rx_byte, 8'h33);
        pulse(1);
    endtask

    task automatic t_frame_err();
        send_frame(8'h44, ~^8'h44, 1'b0, 0, 1);
        check("R4 ferr", frame_err, 1);
        check("R4 byte kept", rx_byte, 8'h33);
        check("R4 no valid", rx_valid, 0);
        check("R5 busy draining", rx_busy, 1);
        for (int k = 0; k < 3; k++) begin
            ps2_clk_pin = 1'b0; wait_cyc(HALF);
            ps2_clk_pin = 1'b1; wait_cyc(HALF);
        end
        check("R5 still draining", rx_busy, 1);
        check("R5 extra clocks ignored", rx_valid, 0);
        ps2_data_pin = 1'b1;
        wait_cyc(5);
        check("R5 idle after release", rx_busy, 0);
        send_frame(8'h55, ~^8'h55, 1'b1, 0, 0);
        check("R5 next frame", rx_byte, 8'h55);
        pulse(1);
        check("R6 still set", frame_err, 1);
        pulse(2);
        check("R6 cleared", frame_err, 0);
        send_frame(8'h66, ~^8'h66, 1'b0, 2, 1);
        check("R6 set beats clear", frame_err, 1);
        ps2_data_pin = 1'b1;
        wait_cyc(5);
        pulse(2);
        check("R6 cleared again", frame_err, 0);
    endtask

    task automatic t_timeout();
        logic [3:0] bits;
        bits = 4'b0110;
        for (int i = 0; i < 4; i++) begin
            ps2_data_pin = bits[i];
            wait_cyc(HALF);
            ps2_clk_pin = 1'b0; wait_cyc(HALF);
            ps2_clk_pin = 1'b1;
        end
        ps2_data_pin = 1'b1;
        wait_cyc(TMO / 2);
        check("R9 busy mid frame", rx_busy, 1);
        wait_cyc(TMO);
        check("R10 timeout idle", rx_busy, 0);
        check("R10 partial discarded", rx_valid, 0);
        send_frame(8'h96, ~^8'h96, 1'b1, 0, 0);
        check("R10 recovers", rx_byte, 8'h96);
        check("R10 recovers valid", rx_valid, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_levels();
        t_basic();
        t_parity();
        t_overrun();
        t_read_clash();
        t_frame_err();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule